// File: doc/BRIEF.md
# Load/Store Execution Unit

This block runs one memory operation at a time for a 16-bit, word-addressed machine. A reservation station hands it an operation: a base register value, a 6-bit signed displacement, the write data if the operation is a store, and a result tag. The unit registers the operation. It spends one cycle forming the effective address, then two cycles in a synchronous word memory that sits inside the block. A store ends with a one-cycle completion strobe back to its station. A load raises a request for the result bus and keeps its tag and data there until the bus grants it.

The controller is a five-state machine:

- `ST_IDLE` waits for work.
- `ST_AGEN` forms the address.
- `ST_MEM1` issues the memory read or write.
- `ST_MEM2` finishes the access; a store signals completion here.
- `ST_WAIT` holds a load result until it is granted.

The transitions are:

- `ST_IDLE`→`ST_AGEN` on accept (`op_valid` while idle).
- `ST_AGEN`→`ST_MEM1` and `ST_MEM1`→`ST_MEM2`, unconditionally.
- `ST_MEM2`→`ST_IDLE` for a store (store done).
- `ST_MEM2`→`ST_WAIT` for a load.
- `ST_WAIT`→`ST_IDLE` on `res_grant` (result delivered).

The memory holds 2^MEM_AW words and is indexed by the low MEM_AW bits of the 16-bit address. A system with several load or store stations places one instance of this unit per station.

Top module: `ldst_unit`

## Requirements
- R1: The effective address is `op_base` plus `op_offset` sign-extended from 6 bits (range -32..31), taken modulo 2^16. The memory word used is selected by the low MEM_AW bits of that address (MEM_AW = 8 by default).
- R2: An operation is accepted on a rising edge where `op_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle until the operation completes.
- R3: An operation offered while `busy` is 1 is ignored: it writes no memory and produces neither a completion nor a result.
- R4: A store (`op_is_store` = 1) writes `op_data` to the addressed word. A later load of that word returns the value.
- R5: For a store accepted at edge k, `st_done` is 1 for exactly the cycle after edge k+2, with `st_tag` equal to the operation's tag. `res_req` and `res_valid` stay 0, and `busy` is 0 in the following cycle.
- R6: For a load (`op_is_store` = 0) accepted at edge k, `res_req` rises after edge k+3. At that point `res_tag` carries the tag and `res_data` carries the memory word.
- R7: While `res_req` is 1 and `res_grant` is 0, `res_req`, `res_tag` and `res_data` hold their values.
- R8: `res_valid` is 1 only in a cycle where `res_req` and `res_grant` are both 1, and only for that single cycle. `busy` is 0 in the next cycle.
- R9: After reset, `busy`, `res_req`, `res_valid` and `st_done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation offered |
| op_is_store | input | 1 | 1 = store, 0 = load |
| op_base | input | 16 | Base register value |
| op_offset | input | 6 | Signed displacement |
| op_data | input | 16 | Store data |
| op_tag | input | TAG_W | Operation tag |
| busy | output | 1 | Operation in flight; new offers refused |
| st_done | output | 1 | Store completion strobe |
| st_tag | output | TAG_W | Tag of the completing store |
| res_req | output | 1 | Load result waiting for the bus |
| res_grant | input | 1 | Result bus grant |
| res_valid | output | 1 | Result delivered this cycle |
| res_tag | output | TAG_W | Tag of the load result |
| res_data | output | 16 | Loaded word |

## Verification
Two events can land in the same cycle. The first is a new offer on `op_valid` arriving in the cycle where the previous operation finishes, either through the grant of a waiting load or through a store's completion. The bench keeps a decoy store asserted during every busy cycle and switches to the real operation only once `busy` reads 0. Any early acceptance of the decoy shows up as an unexpected completion, or as corrupted data in a later load of the decoy's target word. The second is a grant arriving in the very first cycle of a request, which is exercised alongside stalled grants. Here the scoreboard judges the tag, the data, the stability of the held result and the exact cycle of each strobe.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AGEN,
        ST_MEM1,
        ST_MEM2,
        ST_WAIT
    } ls_state_e;

    localparam int WORD_W = 16;
    localparam int DISP_W = 6;

endpackage

// File: rtl/ldst_agen.sv
module ldst_agen
    import ldst_pkg::*;
(
    input  logic [WORD_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    output logic [WORD_W-1:0] eff_addr
);
    logic [WORD_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{(WORD_W-DISP_W){disp[DISP_W-1]}}, disp};
        eff_addr = base + disp_ext;
    end
endmodule

// File: rtl/ldst_mem.sv
module ldst_mem
    import ldst_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [MEM_AW-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [WORD_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[addr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= words[addr];
        end
    end
endmodule

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
    import ldst_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_is_store,
    input  logic [WORD_W-1:0] op_base,
    input  logic [DISP_W-1:0] op_offset,
    input  logic [WORD_W-1:0] op_data,
    input  logic [TAG_W-1:0]  op_tag,
    output logic [WORD_W-1:0] agen_base,
    output logic [DISP_W-1:0] agen_disp,
    input  logic [WORD_W-1:0] agen_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              st_done,
    output logic [TAG_W-1:0]  st_tag,
    output logic              res_req,
    input  logic              res_grant,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [WORD_W-1:0] res_data
);
    ls_state_e state_q, state_d;

    logic              store_q;
    logic [WORD_W-1:0] base_q;
    logic [DISP_W-1:0] disp_q;
    logic [WORD_W-1:0] data_q;
    logic [TAG_W-1:0]  tag_q;
    logic [WORD_W-1:0] addr_q;
    logic              accept;

    assign accept = op_valid && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)    state_d = ST_AGEN;
            ST_AGEN:                state_d = ST_MEM1;
            ST_MEM1:                state_d = ST_MEM2;
            ST_MEM2:                state_d = store_q ? ST_IDLE : ST_WAIT;
            ST_WAIT: if (res_grant) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // operand capture and address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= 1'b0;
            base_q  <= '0;
            disp_q  <= '0;
            data_q  <= '0;
            tag_q   <= '0;
            addr_q  <= '0;
        end else begin
            if (accept) begin
                store_q <= op_is_store;
                base_q  <= op_base;
                disp_q  <= op_offset;
                data_q  <= op_data;
                tag_q   <= op_tag;
            end
            if (state_q == ST_AGEN) begin
                addr_q <= agen_addr;
            end
        end
    end

    // outputs
    always_comb begin
        agen_base = base_q;
        agen_disp = disp_q;
        mem_addr  = addr_q;
        mem_wdata = data_q;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        busy      = 1'b1;
        st_done   = 1'b0;
        res_req   = 1'b0;
        res_valid = 1'b0;
        st_tag    = tag_q;
        res_tag   = tag_q;
        res_data  = mem_rdata;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_AGEN: ;
            ST_MEM1: begin
                mem_we = store_q;
                mem_re = !store_q;
            end
            ST_MEM2: st_done = store_q;
            ST_WAIT: begin
                res_req   = 1'b1;
                res_valid = res_grant;
            end
            default: ;
        endcase
    end

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy) |=> busy);

    // R5
    store_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |=> (!busy && !st_done));

    // R5
    store_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_done |-> (!res_req && !res_valid));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_req && !res_grant) |=> (res_req && $stable(res_tag) && $stable(res_data)));

    // R8
    result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && !busy));

    // R8
    valid_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_req && res_grant));
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
    import ldst_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_is_store,
    input  logic [15:0]       op_base,
    input  logic [5:0]        op_offset,
    input  logic [15:0]       op_data,
    input  logic [TAG_W-1:0]  op_tag,
    output logic              busy,
    output logic              st_done,
    output logic [TAG_W-1:0]  st_tag,
    output logic              res_req,
    input  logic              res_grant,
    output logic              res_valid,
    output logic [TAG_W-1:0]  res_tag,
    output logic [15:0]       res_data
);
    logic [WORD_W-1:0] agen_base;
    logic [DISP_W-1:0] agen_disp;
    logic [WORD_W-1:0] agen_addr;
    logic              mem_we;
    logic              mem_re;
    logic [WORD_W-1:0] mem_addr;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_rdata;

    ldst_agen u_agen (
        .base     (agen_base),
        .disp     (agen_disp),
        .eff_addr (agen_addr)
    );

    ldst_ctrl #(.TAG_W(TAG_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_is_store (op_is_store),
        .op_base     (op_base),
        .op_offset   (op_offset),
        .op_data     (op_data),
        .op_tag      (op_tag),
        .agen_base   (agen_base),
        .agen_disp   (agen_disp),
        .agen_addr   (agen_addr),
        .mem_we      (mem_we),
        .mem_re      (mem_re),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata),
        .busy        (busy),
        .st_done     (st_done),
        .st_tag      (st_tag),
        .res_req     (res_req),
        .res_grant   (res_grant),
        .res_valid   (res_valid),
        .res_tag     (res_tag),
        .res_data    (res_data)
    );

    ldst_mem #(.MEM_AW(MEM_AW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (mem_addr[MEM_AW-1:0]),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    // R3
    no_access_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));
endmodule

// File: tb/test_ldst_unit.sv
`timescale 1ns/1ps
module test_ldst_unit;
    localparam int TAG_W = 4;

    typedef struct {
        logic             is_store;
        logic [TAG_W-1:0] tag;
        logic [15:0]      data;
        int               acc;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic op_is_store = 1'b0;
    logic [15:0] op_base = '0;
    logic [5:0]  op_offset = '0;
    logic [15:0] op_data = '0;
    logic [TAG_W-1:0] op_tag = '0;
    logic busy, st_done, res_req, res_valid;
    logic res_grant = 1'b0;
    logic [TAG_W-1:0] st_tag, res_tag;
    logic [15:0] res_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] model [256];
    exp_t sb[$];

    always #2 clk = ~clk;

    ldst_unit #(.TAG_W(TAG_W), .MEM_AW(8)) i_ldst_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_store(op_is_store),
        .op_base(op_base), .op_offset(op_offset), .op_data(op_data), .op_tag(op_tag),
        .busy(busy), .st_done(st_done), .st_tag(st_tag), .res_req(res_req),
        .res_grant(res_grant), .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    // grant generator, settles after the edge
    always @(posedge clk) begin
        #1;
        res_grant = res_req && (!stall_mode || (lfsr[0] && lfsr[3]));
    end

    // driver: decoy store while busy, real op once idle
    task automatic issue(input bit st, input logic [15:0] base, input logic [5:0] off,
                         input logic [15:0] data, input logic [TAG_W-1:0] tag);
        exp_t e;
        logic [15:0] ea;
        @(negedge clk);
        while (busy) begin
            op_valid = 1'b1; op_is_store = 1'b1; op_base = 16'h005F;
            op_offset = 6'h00; op_data = 16'hDEAD; op_tag = '1;
            @(negedge clk);
        end
        op_valid = 1'b1; op_is_store = st; op_base = base;
        op_offset = off; op_data = data; op_tag = tag;
        ea = base + {{10{off[5]}}, off};
        e.is_store = st; e.tag = tag; e.acc = cyc + 1;
        if (st) begin
            model[ea[7:0]] = data;
            e.data = data;
        end else begin
            e.data = model[ea[7:0]];
        end
        sb.push_back(e);
        @(negedge clk);
        op_valid = 1'b1; op_is_store = 1'b1; op_base = 16'h005F;
        op_offset = 6'h00; op_data = 16'hDEAD; op_tag = '1;
    endtask

    // monitor / scoreboard
    bit expect_idle = 1'b0;
    bit seen_req = 1'b0;
    logic [15:0] prev_data;
    logic [TAG_W-1:0] prev_tag;
    always @(negedge clk) begin
        if (rst_n) begin
            if (expect_idle) begin
                chk(!busy, "R8/R5 idle after completion", busy, 0);
                expect_idle = 1'b0;
            end
            if (st_done) begin
                if (sb.size() == 0) chk(0, "R3 unexpected store done", st_tag, 0);
                else begin
                    chk(sb[0].is_store, "R5 done on a store", 0, 1);
                    chk(st_tag == sb[0].tag, "R5 store tag", st_tag, sb[0].tag);
                    chk(cyc == sb[0].acc + 2, "R5 store timing", cyc, sb[0].acc + 2);
                    chk(!res_req && !res_valid, "R5 no result", res_req, 0);
                    void'(sb.pop_front());
                    expect_idle = 1'b1;
                end
            end
            if (res_req) begin
                if (sb.size() == 0 || sb[0].is_store) begin
                    chk(0, "R3/R6 unexpected result request", res_tag, 0);
                end else if (!seen_req) begin
                    chk(cyc == sb[0].acc + 3, "R6 load timing", cyc, sb[0].acc + 3);
                    chk(res_tag == sb[0].tag, "R6 load tag", res_tag, sb[0].tag);
                    chk(res_data == sb[0].data, "R4 R1 load data", res_data, sb[0].data);
                    seen_req = 1'b1;
                end else begin
                    chk(res_data == prev_data && res_tag == prev_tag, "R7 held result",
                        res_data, prev_data);
                end
                prev_data = res_data;
                prev_tag  = res_tag;
                if (res_valid && sb.size() != 0 && !sb[0].is_store) begin
                    chk(res_grant, "R8 valid with grant", res_grant, 1);
                    void'(sb.pop_front());
                    seen_req = 1'b0;
                    expect_idle = 1'b1;
                end
            end else begin
                if (res_valid) chk(0, "R8 valid without request", res_valid, 0);
                if (seen_req) chk(0, "R7 request dropped without grant", 0, 1);
                seen_req = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        #(4 * 100000);
        chk(0, "watchdog", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1;
        chk(!busy && !st_done && !res_req && !res_valid, "R9 reset outputs",
            {busy, st_done, res_req, res_valid}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !res_req, "R9 idle after reset", busy, 0);

        // R4 basic store/load, R1 positive offset
        issue(1, 16'h0010, 6'h05, 16'h1234, 4'h1);
        issue(0, 16'h0015, 6'h00, 16'h0000, 4'h2);
        // R1 wrap past 0xFFFF
        issue(1, 16'hFFFF, 6'h01, 16'hBEEF, 4'h3);
        issue(0, 16'h0002, 6'h3E, 16'h0000, 4'h4);
        // R1 most negative offset wrapping below zero, low-bit indexing
        issue(1, 16'h0005, 6'h20, 16'h5A5A, 4'h5);
        issue(0, 16'h00E0, 6'h05, 16'h0000, 4'h6);
        // R3 decoy targets 0x5F while busy; value must survive
        issue(1, 16'h0040, 6'h1F, 16'h7777, 4'h7);
        issue(1, 16'h0050, 6'h00, 16'h1111, 4'h8);
        issue(0, 16'h005F, 6'h00, 16'h0000, 4'h9);

        // R7 R8 stalled grants
        stall_mode = 1'b1;
        for (int i = 0; i < 24; i++) begin
            logic [15:0] d;
            logic [7:0]  a;
            d = lfsr ^ 16'(i * 37);
            a = 8'h60 + 8'(i % 8);
            issue(1, {8'h00, a}, 6'h00, d, 4'(i));
            issue(0, {8'h00, a} + 16'd3, 6'h3D, 16'h0000, 4'(i + 1));
        end
        issue(0, 16'h005F, 6'h00, 16'h0000, 4'hA);

        @(negedge clk);
        op_valid = 1'b0;
        while (sb.size() != 0 || busy) @(negedge clk);
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule